// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches the inputs of a four-port GPIO bank and turns selected pins into interrupts. The bank does not get one interrupt per pin. It has eight shared interrupt groups instead. Each group takes its source from one physical pin. A pin whose index inside its port is n can only feed group n mod 8. For each group, software picks the source pin and a 3-bit trigger code. The trigger code selects off, level-high, level-low, always-asserted, rising-edge, falling-edge or either-edge detection.

Every pin passes through a synchronizer first. A level mode makes the group status follow the pin directly. An edge mode makes the group status latch until software writes a one to the matching bit of the acknowledge register. The group status bits are ANDed with an 8-bit mask. The masked bits are ORed into a single registered interrupt line. A 32-bit register bus carries all configuration. The same bus reads back the synchronized port levels and the masked status.

Top module: `gpio_irq_grouper`

## Requirements
- R1: After reset, the following registers all read 0 and the interrupt output is low: trigger codes, pin selects, mask and masked status.
- R2: The trigger register sits at offset 120. It holds a 3-bit code for group g in bits [3g+2:3g], and bits 31:24 read 0. The pin-select register sits at offset 124. It holds a 4-bit value for group g in bits [4g+3:4g]. The mask register sits at offset 128 and uses bits 7:0; bits 31:8 read 0.
- R3: A select value p connects group g to port p/4 (A=0, B=1, C=2, D=3), bit 8*(p mod 4)+g. A bit position beyond the width of the chosen port (port C is 16 bits wide) is seen as a constant 0.
- R4: Code 1 (level high) makes the group status equal to the synchronized pin. Code 2 (level low) makes it equal to the inverted pin. Neither code holds a value after the pin returns.
- R5: Code 3 keeps the group status at 1. Codes 0 and 4 keep it at 0 whatever the pin does.
- R6: Code 5 latches the status on a rising edge of the selected pin. Code 6 latches it on a falling edge. Code 7 latches it on either edge. A latched status stays 1 after the pin changes back.
- R7: Writing a 1 to bit g of the acknowledge register (offset 132) clears the latched status of group g. Bits written as 0 leave their groups unchanged. If a new edge arrives in the same cycle as an acknowledge, the status stays set.
- R8: The masked-status register at offset 140 reads as the group status ANDed with the mask, in bits 7:0.
- R9: The interrupt output is a register. It equals the OR of the masked-status bits one clock earlier.
- R10: Reads from offsets with no register, including the write-only acknowledge offset, return 0. Writes to offsets with no register change nothing.
- R11: Offsets 0, 44, 88 and 116 read the synchronized levels of ports A, B, C and D, zero-extended to 32 bits.
- R12: A pin change is visible in the status after two clock edges. In a level mode this shows in the masked status after the second edge. In an edge mode the status latches on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address, 0 when not selected |
| port_a | input | PA_W | Port A pin levels |
| port_b | input | PB_W | Port B pin levels |
| port_c | input | PC_W | Port C pin levels |
| port_d | input | PD_W | Port D pin levels, input only |
| irq | output | 1 | Combined interrupt line |

## Verification
An edge that is being latched and an acknowledge write for the same group can happen in the same clock cycle. The bench provokes this in three steps. It first latches a rising edge. It then lowers the pin and raises it again. Two clock edges after the pin rises, it issues the acknowledge write, so the write lands in the cycle where the synchronized edge is detected. The group must still read as set afterwards. A separate case with no new edge shows that the same acknowledge clears the bit.

// File: rtl/gig_pkg.sv
package gig_pkg;
   localparam int GROUPS = 8;
   localparam int PORTS  = 4;
   localparam int LANE_W = 32;
   localparam int CODE_W = 3;
   localparam int SEL_W  = 4;

   typedef enum logic [CODE_W-1:0] {
      TRIG_NONE = 3'd0,
      TRIG_HIGH = 3'd1,
      TRIG_LOW  = 3'd2,
      TRIG_ON   = 3'd3,
      TRIG_RSV  = 3'd4,
      TRIG_RISE = 3'd5,
      TRIG_FALL = 3'd6,
      TRIG_BOTH = 3'd7
   } trig_e;
endpackage

// File: rtl/gig_sync.sv
module gig_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gig_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gig_group.sv
module gig_group
   import gig_pkg::*;
#(
   parameter int G = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PORTS-1:0][LANE_W-1:0]  lanes,
   input  logic [SEL_W-1:0]              sel,
   input  logic [CODE_W-1:0]             mode,
   input  logic                          ack,
   output logic                          raw,
   output logic                          stat,
   output logic                          set
);
   if (G < 0 || G >= GROUPS) begin : g_bad_group
      $error("gig_group: group index out of range");
   end

   localparam logic [2:0] G_BITS = 3'(G);

   trig_e code;
   logic  pin, prev_q, edge_q, rise, fall;

   assign code = trig_e'(mode);
   assign pin  = lanes[sel[3:2]][{sel[1:0], G_BITS}];
   assign rise = pin & ~prev_q;
   assign fall = ~pin & prev_q;

   always_comb begin
      case (code)
         TRIG_RISE: set = rise;
         TRIG_FALL: set = fall;
         TRIG_BOTH: set = rise | fall;
         default:   set = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         prev_q <= pin;
         edge_q <= (edge_q & ~ack) | set;
      end
   end

   always_comb begin
      case (code)
         TRIG_HIGH:                     raw = pin;
         TRIG_LOW:                      raw = ~pin;
         TRIG_ON:                       raw = 1'b1;
         TRIG_RISE, TRIG_FALL, TRIG_BOTH: raw = edge_q;
         default:                       raw = 1'b0;
      endcase
   end

   assign stat = edge_q;
endmodule

// File: rtl/gpio_irq_grouper.sv
module gpio_irq_grouper
   import gig_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PA_W        = 32,
   parameter int PB_W        = 32,
   parameter int PC_W        = 16,
   parameter int PD_W        = 32,
   parameter int SYNC_STAGES = 2,
   parameter int OFF_PA      = 0,
   parameter int OFF_PB      = 44,
   parameter int OFF_PC      = 88,
   parameter int OFF_PD      = 116,
   parameter int OFF_TRIG    = 120,
   parameter int OFF_PSEL    = 124,
   parameter int OFF_MASK    = 128,
   parameter int OFF_ACK     = 132,
   parameter int OFF_MSTAT   = 140
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PA_W-1:0]   port_a,
   input  logic [PB_W-1:0]   port_b,
   input  logic [PC_W-1:0]   port_c,
   input  logic [PD_W-1:0]   port_d,
   output logic              irq
);
   localparam int TRIG_W    = GROUPS * CODE_W;
   localparam int PSEL_W    = GROUPS * SEL_W;
   localparam int PIN_TOTAL = PA_W + PB_W + PC_W + PD_W;
   localparam int B_LO      = PA_W;
   localparam int C_LO      = PA_W + PB_W;
   localparam int D_LO      = PA_W + PB_W + PC_W;
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (PA_W < 1 || PA_W > LANE_W || PB_W < 1 || PB_W > LANE_W ||
       PC_W < 1 || PC_W > LANE_W || PD_W < 1 || PD_W > LANE_W) begin : g_bad_width
      $error("gpio_irq_grouper: port widths must be 1..32");
   end
   if (OFF_MSTAT >= ADDR_SPAN || OFF_ACK >= ADDR_SPAN || OFF_MASK >= ADDR_SPAN ||
       OFF_PSEL >= ADDR_SPAN || OFF_TRIG >= ADDR_SPAN || OFF_PD >= ADDR_SPAN) begin : g_bad_map
      $error("gpio_irq_grouper: register offset does not fit ADDR_W");
   end

   // ---- pin synchronizer and lane padding
   logic [PIN_TOTAL-1:0]            pins_s;
   logic [PORTS-1:0][LANE_W-1:0]    lanes;

   gig_sync #(.W(PIN_TOTAL), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({port_d, port_c, port_b, port_a}),
      .q     (pins_s)
   );

   always_comb begin
      lanes = '0;
      lanes[0][PA_W-1:0] = pins_s[PA_W-1:0];
      lanes[1][PB_W-1:0] = pins_s[B_LO +: PB_W];
      lanes[2][PC_W-1:0] = pins_s[C_LO +: PC_W];
      lanes[3][PD_W-1:0] = pins_s[D_LO +: PD_W];
   end

   // ---- address decode
   logic wr_en;
   logic hit_pa, hit_pb, hit_pc, hit_pd, hit_trig, hit_psel, hit_mask, hit_ack, hit_mstat;

   assign wr_en     = bus_sel & bus_wr;
   assign hit_pa    = (bus_addr == ADDR_W'(OFF_PA));
   assign hit_pb    = (bus_addr == ADDR_W'(OFF_PB));
   assign hit_pc    = (bus_addr == ADDR_W'(OFF_PC));
   assign hit_pd    = (bus_addr == ADDR_W'(OFF_PD));
   assign hit_trig  = (bus_addr == ADDR_W'(OFF_TRIG));
   assign hit_psel  = (bus_addr == ADDR_W'(OFF_PSEL));
   assign hit_mask  = (bus_addr == ADDR_W'(OFF_MASK));
   assign hit_ack   = (bus_addr == ADDR_W'(OFF_ACK));
   assign hit_mstat = (bus_addr == ADDR_W'(OFF_MSTAT));

   // ---- configuration registers
   logic [TRIG_W-1:0] trig_q;
   logic [PSEL_W-1:0] psel_q;
   logic [GROUPS-1:0] mask_q;
   logic [GROUPS-1:0] ack_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= '0;
         psel_q <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         if (hit_trig) trig_q <= bus_wdata[TRIG_W-1:0];
         if (hit_psel) psel_q <= bus_wdata[PSEL_W-1:0];
         if (hit_mask) mask_q <= bus_wdata[GROUPS-1:0];
      end
   end

   assign ack_v = (wr_en && hit_ack) ? bus_wdata[GROUPS-1:0] : '0;

   // ---- interrupt groups
   logic [GROUPS-1:0] raw_v, stat_q, set_v, masked_v;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      gig_group #(.G(g)) u_grp (
         .clk   (clk),
         .rst_n (rst_n),
         .lanes (lanes),
         .sel   (psel_q[SEL_W*g +: SEL_W]),
         .mode  (trig_q[CODE_W*g +: CODE_W]),
         .ack   (ack_v[g]),
         .raw   (raw_v[g]),
         .stat  (stat_q[g]),
         .set   (set_v[g])
      );
   end

   assign masked_v = raw_v & mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |masked_v;
   end

   // ---- read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (hit_pa)    bus_rdata = lanes[0];
         if (hit_pb)    bus_rdata = lanes[1];
         if (hit_pc)    bus_rdata = lanes[2];
         if (hit_pd)    bus_rdata = lanes[3];
         if (hit_trig)  bus_rdata = 32'(trig_q);
         if (hit_psel)  bus_rdata = 32'(psel_q);
         if (hit_mask)  bus_rdata = 32'(mask_q);
         if (hit_mstat) bus_rdata = 32'(masked_v);
      end
   end
endmodule

// File: rtl/gpio_irq_grouper_chk.sv
module gpio_irq_grouper_chk #(
   parameter int ADDR_W    = 8,
   parameter int OFF_PA    = 0,
   parameter int OFF_PB    = 44,
   parameter int OFF_PC    = 88,
   parameter int OFF_PD    = 116,
   parameter int OFF_TRIG  = 120,
   parameter int OFF_PSEL  = 124,
   parameter int OFF_MASK  = 128,
   parameter int OFF_MSTAT = 140
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              irq,
   input logic [7:0]        mask_q,
   input logic [7:0]        stat_q,
   input logic [7:0]        set_v,
   input logic [7:0]        ack_v,
   input logic [7:0]        masked
);
   logic readable;
   assign readable = (bus_addr == ADDR_W'(OFF_PA))   || (bus_addr == ADDR_W'(OFF_PB))   ||
                     (bus_addr == ADDR_W'(OFF_PC))   || (bus_addr == ADDR_W'(OFF_PD))   ||
                     (bus_addr == ADDR_W'(OFF_TRIG)) || (bus_addr == ADDR_W'(OFF_PSEL)) ||
                     (bus_addr == ADDR_W'(OFF_MASK)) || (bus_addr == ADDR_W'(OFF_MSTAT));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (irq == 1'b0 && mask_q == 8'h00 && stat_q == 8'h00)
            else $error("R1 state not clear in reset");
      end
   end

   assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|masked));

   assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 8'h00) |=> !irq);

   assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack_v & ~set_v)) |=> ((stat_q & $past(ack_v & ~set_v)) == 8'h00));

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v) |=> ((stat_q & $past(set_v)) == $past(set_v)));

   assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q & ~ack_v)) |=> ((stat_q & $past(stat_q & ~ack_v)) == $past(stat_q & ~ack_v)));

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !readable) |-> (bus_rdata == 32'h0));
endmodule

bind gpio_irq_grouper gpio_irq_grouper_chk #(
   .ADDR_W(ADDR_W), .OFF_PA(OFF_PA), .OFF_PB(OFF_PB), .OFF_PC(OFF_PC), .OFF_PD(OFF_PD),
   .OFF_TRIG(OFF_TRIG), .OFF_PSEL(OFF_PSEL), .OFF_MASK(OFF_MASK), .OFF_MSTAT(OFF_MSTAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .mask_q    (mask_q),
   .stat_q    (stat_q),
   .set_v     (set_v),
   .ack_v     (ack_v),
   .masked    (masked_v)
);

// File: tb/gpio_irq_grouper_test.sv
module gpio_irq_grouper_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_PA = 8'd0, A_PB = 8'd44, A_PC = 8'd88, A_PD = 8'd116;
   localparam logic [7:0] A_TRIG = 8'd120, A_PSEL = 8'd124, A_MASK = 8'd128;
   localparam logic [7:0] A_ACK = 8'd132, A_MSTAT = 8'd140;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] port_a = '0;
   logic [31:0] port_b = '0;
   logic [15:0] port_c = '0;
   logic [31:0] port_d = '0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_grouper uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_a(port_a), .port_b(port_b),
      .port_c(port_c), .port_d(port_d), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      peek(a, d);
   endtask

   function automatic logic [31:0] code_at(input int g, input logic [2:0] c);
      return 32'(c) << (3*g);
   endfunction

   function automatic logic [31:0] sel_at(input int g, input logic [3:0] p);
      return 32'(p) << (4*g);
   endfunction

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_read(A_TRIG, d);  check("R1 trig", d, 32'h0);
      bus_read(A_PSEL, d);  check("R1 psel", d, 32'h0);
      bus_read(A_MASK, d);  check("R1 mask", d, 32'h0);
      bus_read(A_MSTAT, d); check("R1 mstat", d, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      bus_write(A_TRIG, 32'hFFFF_FFFF); bus_read(A_TRIG, d); check("R2 trig width", d, 32'h00FF_FFFF);
      bus_write(A_PSEL, 32'h1234_5678); bus_read(A_PSEL, d); check("R2 psel", d, 32'h1234_5678);
      bus_write(A_MASK, 32'hFFFF_FFA5); bus_read(A_MASK, d); check("R2 mask width", d, 32'h0000_00A5);
      bus_write(A_TRIG, 32'h0); bus_write(A_PSEL, 32'h0); bus_write(A_MASK, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      bus_write(A_PSEL, 32'h0);
      bus_write(A_TRIG, code_at(0, 3'd1));
      bus_write(A_MASK, 32'h01);
      port_a[0] = 1'b1;
      @(posedge clk); #1; peek(A_MSTAT, d); check("R12 one edge not yet", d, 32'h00);
      @(posedge clk); #1; peek(A_MSTAT, d); check("R12 level after two edges", d, 32'h01);
      check("R9 irq lags masked", 32'(irq), 32'h0);
      @(posedge clk); #1; check("R9 irq registered", 32'(irq), 32'h1);
      @(negedge clk); port_a[0] = 1'b0;
      settle(); bus_read(A_MSTAT, d); check("R4 high not latched", d, 32'h00);
      check("R9 irq drops", 32'(irq), 32'h0);
      bus_write(A_TRIG, code_at(0, 3'd2));
      settle(); bus_read(A_MSTAT, d); check("R4 low active", d, 32'h01);
      port_a[0] = 1'b1;
      settle(); bus_read(A_MSTAT, d); check("R4 low released", d, 32'h00);
      port_a[0] = 1'b0;
      bus_write(A_TRIG, 32'h0);
   endtask

   task automatic t_always();
      logic [31:0] d;
      bus_write(A_MASK, 32'h08);
      port_a[3] = 1'b1;
      bus_write(A_TRIG, code_at(3, 3'd3)); settle(); bus_read(A_MSTAT, d); check("R5 code3", d, 32'h08);
      bus_write(A_TRIG, code_at(3, 3'd4)); settle(); bus_read(A_MSTAT, d); check("R5 code4", d, 32'h00);
      bus_write(A_TRIG, code_at(3, 3'd0)); settle(); bus_read(A_MSTAT, d); check("R5 code0", d, 32'h00);
      check("R5 irq off", 32'(irq), 32'h0);
      port_a[3] = 1'b0;
   endtask

   task automatic t_select();
      logic [31:0] d;
      bus_write(A_MASK, 32'h20);
      bus_write(A_TRIG, code_at(5, 3'd1));
      bus_write(A_PSEL, sel_at(5, 4'd6));
      port_b[5] = 1'b1; settle(); bus_read(A_MSTAT, d); check("R3 wrong pin ignored", d, 32'h00);
      port_b[21] = 1'b1; settle(); bus_read(A_MSTAT, d); check("R3 sel6 portB bit21", d, 32'h20);
      port_b = '0;
      bus_write(A_PSEL, sel_at(5, 4'd9));
      port_c[13] = 1'b1; settle(); bus_read(A_MSTAT, d); check("R3 sel9 portC bit13", d, 32'h20);
      bus_write(A_PSEL, sel_at(5, 4'd15));
      settle(); bus_read(A_MSTAT, d); check("R3 sel15 portD low", d, 32'h00);
      port_d[29] = 1'b1; settle(); bus_read(A_MSTAT, d); check("R3 sel15 portD bit29", d, 32'h20);
      port_c = 16'hFFFF;
      bus_write(A_TRIG, code_at(5, 3'd2));
      bus_write(A_PSEL, sel_at(5, 4'd10));
      settle(); bus_read(A_MSTAT, d); check("R3 beyond portC reads 0", d, 32'h20);
      port_c = '0; port_d = '0;
      bus_write(A_TRIG, 32'h0); bus_write(A_PSEL, 32'h0);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      bus_write(A_MASK, 32'h04);
      bus_write(A_TRIG, code_at(2, 3'd5));
      port_a[2] = 1'b1;
      @(posedge clk); @(posedge clk); #1; peek(A_MSTAT, d); check("R12 edge not yet", d, 32'h00);
      @(posedge clk); #1; peek(A_MSTAT, d); check("R12 edge at third", d, 32'h04);
      @(negedge clk); port_a[2] = 1'b0;
      settle(); bus_read(A_MSTAT, d); check("R6 rise latched", d, 32'h04);
      check("R9 irq from edge", 32'(irq), 32'h1);
      bus_write(A_ACK, 32'h04); bus_read(A_MSTAT, d); check("R7 ack clears", d, 32'h00);
      bus_write(A_TRIG, code_at(2, 3'd6));
      port_a[2] = 1'b1; settle(); bus_read(A_MSTAT, d); check("R6 fall ignores rise", d, 32'h00);
      port_a[2] = 1'b0; settle(); bus_read(A_MSTAT, d); check("R6 fall latched", d, 32'h04);
      bus_write(A_ACK, 32'h04);
      bus_write(A_TRIG, code_at(2, 3'd7));
      port_a[2] = 1'b1; settle(); bus_read(A_MSTAT, d); check("R6 both rise", d, 32'h04);
      bus_write(A_ACK, 32'h04);
      port_a[2] = 1'b0; settle(); bus_read(A_MSTAT, d); check("R6 both fall", d, 32'h04);
      bus_write(A_ACK, 32'h04);
   endtask

   task automatic t_ack();
      logic [31:0] d;
      bus_write(A_MASK, 32'h04);
      bus_write(A_TRIG, code_at(2, 3'd5));
      port_a[2] = 1'b1; settle(); port_a[2] = 1'b0; settle();
      bus_write(A_ACK, 32'hFB); bus_read(A_MSTAT, d); check("R7 zero bit no effect", d, 32'h04);
      @(negedge clk); port_a[2] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h04;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      peek(A_MSTAT, d); check("R7 set wins over ack", d, 32'h04);
      bus_write(A_ACK, 32'h04); bus_read(A_MSTAT, d); check("R7 ack after collision", d, 32'h00);
      port_a[2] = 1'b0; settle();
   endtask

   task automatic t_masked();
      logic [31:0] d;
      port_a[1] = 1'b1; port_a[6] = 1'b1;
      bus_write(A_TRIG, code_at(1, 3'd1) | code_at(6, 3'd1));
      bus_write(A_MASK, 32'h40); settle();
      bus_read(A_MSTAT, d); check("R8 mask filters", d, 32'h40);
      bus_write(A_MASK, 32'h42); bus_read(A_MSTAT, d); check("R8 both unmasked", d, 32'h42);
      bus_write(A_MASK, 32'h00); @(negedge clk);
      bus_read(A_MSTAT, d); check("R8 all masked", d, 32'h00);
      check("R9 irq masked off", 32'(irq), 32'h0);
      port_a = '0; bus_write(A_TRIG, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      bus_write(A_TRIG, code_at(4, 3'd1));
      bus_write(8'd136, 32'hFFFF_FFFF);
      bus_write(8'd12, 32'hFFFF_FFFF);
      bus_read(8'd136, d); check("R10 read 136", d, 32'h0);
      bus_read(8'd12, d);  check("R10 read 12", d, 32'h0);
      bus_read(A_ACK, d);  check("R10 ack write-only", d, 32'h0);
      bus_read(A_TRIG, d); check("R10 trig untouched", d, code_at(4, 3'd1));
      bus_read(A_MASK, d); check("R10 mask untouched", d, 32'h0);
      bus_write(A_TRIG, 32'h0);
   endtask

   task automatic t_ports();
      logic [31:0] d;
      port_a = 32'hDEAD_BEEF; port_b = 32'h0123_4567; port_c = 16'hBEEF; port_d = 32'h8000_0001;
      settle();
      bus_read(A_PA, d); check("R11 port A", d, 32'hDEAD_BEEF);
      bus_read(A_PB, d); check("R11 port B", d, 32'h0123_4567);
      bus_read(A_PC, d); check("R11 port C", d, 32'h0000_BEEF);
      bus_read(A_PD, d); check("R11 port D", d, 32'h8000_0001);
      port_a = '0; port_b = '0; port_c = '0; port_d = '0;
      settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_regs();
      t_level();
      t_always();
      t_select();
      t_edge();
      t_ack();
      t_masked();
      t_unmapped();
      t_ports();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule